// File: doc/BRIEF.md
# UART Register and Command Controller

This block is the software-facing register file of a UART. It sits on a byte-wide synchronous bus and decodes a 64-byte window. Through that window software programs two mode registers, which share one offset and are reached in turn by a pointer. It reads a status byte and an interrupt status byte, sets an interrupt mask, and reads two fixed baud bytes. It writes a packed command byte and moves data through a single offset: writes go to the transmitter and reads come from the receiver.

A command byte carries three fields: a miscellaneous action, a transmitter action and a receiver action. All three are applied in that order within the one write cycle. Transmit bytes are handed to an external serializer on a one-clock strobe. Received bytes and break events arrive from an external deserializer and are held in a small ordered queue. A single interrupt line is raised whenever an unmasked interrupt status bit is set.

Top module: `uart_regctl`

## Requirements
- R1: After reset, status reads 0x08, interrupt status reads 0x00, both mode registers read 0x00, `irq`, `tx_valid` and `rx_ready` are low, and `rdata` is 0x00.
- R2: Offset 0x00 reads and writes the mode register chosen by a pointer that starts at the first register. Any write to 0x00 moves the pointer to the second register, where it stays. Miscellaneous command 1 returns it to the first register.
- R3: Read data appears on `rdata` on the clock after a read access and is 0x00 in every other cycle. Offsets 0x18 and 0x1C return `BAUD_HI` and `BAUD_LO`. Offsets outside {0x00, 0x04, 0x0C, 0x14, 0x18, 0x1C} read 0x00.
- R4: The status byte at 0x04 has these bits: bit0 receive data available (queue not empty), bit1 queue full, bit2 transmitter enabled, bit3 transmit buffer empty. Bits 7:4 read 0.
- R5: The interrupt status byte at 0x14 has these bits: bit0 transmit interrupt, bit1 receive interrupt, bit2 break seen. All other bits read 0. A write to 0x14 sets the mask, and `irq` is high exactly when (status & mask) is nonzero.
- R6: The transmit interrupt equals the transmitter-enabled bit. The receive interrupt follows queue-full when bit 6 of the first mode register is 1, and follows data-available when that bit is 0.
- R7: Command bits 6:4 select the miscellaneous action (0 none, 1 pointer home, 2 receiver reset, 3 transmitter reset, 5 break-flag clear, all others none). Bits 3:2 select the transmitter action and bits 1:0 the receiver action, each coded 0 keep, 1 enable, 2 disable, 3 keep. The fields are applied miscellaneous first, then transmitter, then receiver.
- R8: A write to 0x0C latches the byte. If the transmitter is enabled, the byte leaves on `tx_valid`/`tx_data` in the next clock for one clock and the empty bit stays 1. If it is disabled, the empty bit clears and the byte is held until a transmitter-enable command sends it.
- R9: Transmitter reset disables the transmitter, sets the empty bit and drops any held byte, so a later enable sends nothing.
- R10: `rx_ready` is high when the receiver is enabled and the queue is not full. A byte on `rx_push` is stored only while `rx_ready` is high. Reads of 0x0C return bytes in arrival order and remove them, and a read of an empty queue returns 0x00.
- R11: A break event sets the break-seen flag and stores 0x00 in the queue even with the receiver disabled. When the queue is full, it overwrites the newest entry. Miscellaneous command 5 clears the flag.
- R12: Receiver reset disables the receiver and empties the queue.
- R13: Writes to offsets 0x04 and 0x10, and to unmapped offsets, change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Bus access strobe |
| we | input | 1 | 1 write, 0 read |
| addr | input | 6 | Byte offset in the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| tx_valid | output | 1 | One-clock transmit strobe |
| tx_data | output | 8 | Transmit byte, valid with `tx_valid` |
| rx_push | input | 1 | Received byte present |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Break event, one clock |
| rx_ready | output | 1 | Receiver can take a byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `rx_break` and `rx_push` are never high in the same clock. They also assume that a break never coincides with a break-flag-clear command, and that the bus issues at most one access per clock. The stimulus keeps to this by driving every access, push and break from its own task. Each task holds its input for exactly one clock, and only one task runs at a time. Pushes against a full queue are issued on purpose, with no other event in that clock, so the refusal can be observed in isolation.

// File: rtl/uart_regctl_pkg.sv
package uart_regctl_pkg;

    localparam logic [5:0] OFS_MODE    = 6'h00;
    localparam logic [5:0] OFS_STAT    = 6'h04;
    localparam logic [5:0] OFS_CMD     = 6'h08;
    localparam logic [5:0] OFS_DATA    = 6'h0C;
    localparam logic [5:0] OFS_INT     = 6'h14;
    localparam logic [5:0] OFS_BAUD_HI = 6'h18;
    localparam logic [5:0] OFS_BAUD_LO = 6'h1C;

    typedef enum logic [1:0] {
        DIR_KEEP = 2'd0,
        DIR_ON   = 2'd1,
        DIR_OFF  = 2'd2,
        DIR_RSVD = 2'd3
    } dir_op_e;

    typedef struct packed {
        logic    ptr_home;
        logic    rx_reset;
        logic    tx_reset;
        logic    brk_ack;
        dir_op_e tx_op;
        dir_op_e rx_op;
    } cmd_t;

endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
    import uart_regctl_pkg::*;
(
    input  logic [6:0] cmd_byte,
    output cmd_t       cmd
);

    logic [2:0] misc;

    always_comb begin
        misc         = cmd_byte[6:4];
        cmd.ptr_home = (misc == 3'd1);
        cmd.rx_reset = (misc == 3'd2);
        cmd.tx_reset = (misc == 3'd3);
        cmd.brk_ack  = (misc == 3'd5);
        cmd.tx_op    = dir_op_e'(cmd_byte[3:2]);
        cmd.rx_op    = dir_op_e'(cmd_byte[1:0]);
    end

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             pop,
    input  logic             push,
    input  logic [7:0]       din,
    output logic [7:0]       head,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] slot;
        logic [CNT_W-1:0]      cnt;
    } rxq_t;

    rxq_t q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (flush) begin
            q_d.cnt = '0;
        end else begin
            if (pop && (q_q.cnt != '0)) begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    q_d.slot[i] = q_q.slot[i+1];
                end
                q_d.cnt = q_q.cnt - 1'b1;
            end
            if (push) begin
                if (q_d.cnt == FULL_CNT) begin
                    q_d.slot[DEPTH-1] = din;
                end else begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if (q_d.cnt == CNT_W'(i)) begin
                            q_d.slot[i] = din;
                        end
                    end
                    q_d.cnt = q_d.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign head  = q_q.slot[0];
    assign count = q_q.cnt;

endmodule

// File: rtl/uart_regctl.sv
module uart_regctl
    import uart_regctl_pkg::*;
#(
    parameter int          RXQ_DEPTH = 4,
    parameter logic [7:0]  BAUD_HI   = 8'h00,
    parameter logic [7:0]  BAUD_LO   = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       we,
    input  logic [5:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       rx_push,
    input  logic [7:0] rx_byte,
    input  logic       rx_break,
    output logic       rx_ready,
    output logic       irq
);

    localparam int               CNT_W    = $clog2(RXQ_DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(RXQ_DEPTH);

    typedef struct packed {
        logic [7:0] mode0;
        logic [7:0] mode1;
        logic       ptr;
        logic [7:0] imr;
        logic       brk_seen;
        logic       tx_on;
        logic       rx_on;
        logic       tx_empty;
        logic [7:0] hold;
        logic [7:0] rdata;
        logic       tx_fire;
    } regs_t;

    regs_t            s_d, s_q;
    cmd_t             cmd;
    logic [7:0]       rxq_head;
    logic [CNT_W-1:0] rxq_cnt;
    logic             wr_acc, rd_acc;
    logic             rx_avail, rx_full;
    logic             rxq_flush, rxq_pop, rxq_push;
    logic [7:0]       rxq_din;
    logic [7:0]       status, int_stat, imr_now;

    uart_cmd_decode u_dec (
        .cmd_byte (wdata[6:0]),
        .cmd      (cmd)
    );

    uart_rx_queue #(.DEPTH(RXQ_DEPTH), .CNT_W(CNT_W)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rxq_flush),
        .pop   (rxq_pop),
        .push  (rxq_push),
        .din   (rxq_din),
        .head  (rxq_head),
        .count (rxq_cnt)
    );

    always_comb begin
        wr_acc    = sel && we;
        rd_acc    = sel && !we;
        rx_avail  = (rxq_cnt != '0);
        rx_full   = (rxq_cnt == FULL_CNT);
        rx_ready  = s_q.rx_on && !rx_full;
        status    = {4'b0000, s_q.tx_empty, s_q.tx_on, rx_full, rx_avail};
        int_stat  = {5'b00000, s_q.brk_seen,
                     (s_q.mode0[6] ? rx_full : rx_avail), s_q.tx_on};
        rxq_flush = wr_acc && (addr == OFS_CMD) && cmd.rx_reset;
        rxq_pop   = rd_acc && (addr == OFS_DATA);
        rxq_push  = rx_break || (rx_push && rx_ready);
        rxq_din   = rx_break ? 8'h00 : rx_byte;
    end

    always_comb begin
        s_d         = s_q;
        s_d.tx_fire = 1'b0;
        s_d.rdata   = 8'h00;

        if (rd_acc) begin
            case (addr)
                OFS_MODE:    s_d.rdata = s_q.ptr ? s_q.mode1 : s_q.mode0;
                OFS_STAT:    s_d.rdata = status;
                OFS_DATA:    s_d.rdata = rx_avail ? rxq_head : 8'h00;
                OFS_INT:     s_d.rdata = int_stat;
                OFS_BAUD_HI: s_d.rdata = BAUD_HI;
                OFS_BAUD_LO: s_d.rdata = BAUD_LO;
                default:     s_d.rdata = 8'h00;
            endcase
        end

        if (wr_acc) begin
            case (addr)
                OFS_MODE: begin
                    if (s_q.ptr) s_d.mode1 = wdata;
                    else         s_d.mode0 = wdata;
                    s_d.ptr = 1'b1;
                end
                OFS_CMD: begin
                    if (cmd.ptr_home) s_d.ptr = 1'b0;
                    if (cmd.rx_reset) s_d.rx_on = 1'b0;
                    if (cmd.tx_reset) begin
                        s_d.tx_on    = 1'b0;
                        s_d.tx_empty = 1'b1;
                    end
                    if (cmd.brk_ack) s_d.brk_seen = 1'b0;
                    case (cmd.tx_op)
                        DIR_ON: begin
                            s_d.tx_on = 1'b1;
                            if (!s_d.tx_empty) begin
                                s_d.tx_fire  = 1'b1;
                                s_d.tx_empty = 1'b1;
                            end
                        end
                        DIR_OFF: s_d.tx_on = 1'b0;
                        default: ;
                    endcase
                    case (cmd.rx_op)
                        DIR_ON:  s_d.rx_on = 1'b1;
                        DIR_OFF: s_d.rx_on = 1'b0;
                        default: ;
                    endcase
                end
                OFS_DATA: begin
                    s_d.hold = wdata;
                    if (s_q.tx_on) begin
                        s_d.tx_fire  = 1'b1;
                        s_d.tx_empty = 1'b1;
                    end else begin
                        s_d.tx_empty = 1'b0;
                    end
                end
                OFS_INT: s_d.imr = wdata;
                default: ;
            endcase
        end

        if (rx_break) s_d.brk_seen = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.tx_empty <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign imr_now  = s_q.imr;
    assign rdata    = s_q.rdata;
    assign tx_valid = s_q.tx_fire;
    assign tx_data  = s_q.hold;
    assign irq      = |(int_stat & s_q.imr);

endmodule

// File: rtl/uart_regctl_chk.sv
module uart_regctl_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel,
    input logic             we,
    input logic [5:0]       addr,
    input logic [7:0]       wdata,
    input logic [7:0]       rdata,
    input logic             tx_valid,
    input logic             rx_push,
    input logic             rx_break,
    input logic             rx_ready,
    input logic             irq,
    input logic [7:0]       imr_now,
    input logic [CNT_W-1:0] fill
);

    logic cmd_wr, data_rd;
    assign cmd_wr  = sel && we && (addr == 6'h08);
    assign data_rd = sel && !we && (addr == 6'h0C);

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && !we) |=> (rdata == 8'h00)); // R3

    AST_TX_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(sel && we && (addr == 6'h08 || addr == 6'h0C))); // R8

    AST_TX_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wdata[6:4] == 3'd3 && wdata[3:2] != 2'd1) |=> !tx_valid); // R9

    AST_RX_RESET_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wdata[6:4] == 3'd2 && wdata[1:0] != 2'd1) |=> !rx_ready); // R12

    AST_REFUSED_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_ready && !rx_break && !data_rd && !cmd_wr)
        |=> (fill == $past(fill))); // R10

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (imr_now != 8'h00)); // R5

endmodule

bind uart_regctl uart_regctl_chk #(.DEPTH(RXQ_DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .we       (we),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .tx_valid (tx_valid),
    .rx_push  (rx_push),
    .rx_break (rx_break),
    .rx_ready (rx_ready),
    .irq      (irq),
    .imr_now  (imr_now),
    .fill     (rxq_cnt)
);

// File: tb/tb_uart_regctl.sv
module tb_uart_regctl;

    localparam logic [7:0] BH = 8'hB4;
    localparam logic [7:0] BL = 8'h2D;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, we = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       rx_push = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_break = 1'b0;
    logic       rx_ready;
    logic       irq;

    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;
    logic       txv_seen;
    logic [7:0] txd_seen;
    logic [7:0] v;

    uart_regctl #(.RXQ_DEPTH(4), .BAUD_HI(BH), .BAUD_LO(BL)) dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .rx_push(rx_push), .rx_byte(rx_byte), .rx_break(rx_break),
        .rx_ready(rx_ready), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
        txv_seen = tx_valid;
        txd_seen = tx_data;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] r);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        r = rdata;
        sel = 1'b0;
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        rx_push = 1'b1; rx_byte = d;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic brk();
        @(negedge clk);
        rx_break = 1'b1;
        @(negedge clk);
        rx_break = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=00 exp=01");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
        chk("R1 rx_ready", {7'b0, rx_ready}, 8'h00);
        rd(6'h04, v); chk("R1 R4 status", v, 8'h08);
        rd(6'h14, v); chk("R1 isr", v, 8'h00);
        rd(6'h00, v); chk("R1 mode", v, 8'h00);

        // R2 mode pointer
        wr(6'h00, 8'hA1);
        wr(6'h00, 8'h5C);
        rd(6'h00, v); chk("R2 second", v, 8'h5C);
        wr(6'h00, 8'h66);
        rd(6'h00, v); chk("R2 stays", v, 8'h66);
        wr(6'h08, 8'h10);
        rd(6'h00, v); chk("R2 home", v, 8'hA1);

        // R13 ignored writes, then R3 read sweep of the window
        wr(6'h04, 8'hFF);
        wr(6'h10, 8'hFF);
        wr(6'h24, 8'hFF);
        for (int a = 0; a < 64; a++) begin
            logic [7:0] e;
            if (a == 12) continue;
            case (a)
                0:  e = 8'hA1;
                4:  e = 8'h08;
                24: e = BH;
                28: e = BL;
                default: e = 8'h00;
            endcase
            rd(6'(a), v);
            chk((a == 0 || a == 4) ? "R13 sweep" : "R3 sweep", v, e);
        end

        // R8 transmit path
        wr(6'h0C, 8'h3C); chk("R8 held", {7'b0, txv_seen}, 8'h00);
        rd(6'h04, v); chk("R8 R4 not empty", v, 8'h00);
        wr(6'h08, 8'h04); chk("R8 send on enable", {7'b0, txv_seen}, 8'h01);
        chk("R8 data", txd_seen, 8'h3C);
        rd(6'h04, v); chk("R8 status", v, 8'h0C);
        chk("R8 one clock", {7'b0, tx_valid}, 8'h00);
        wr(6'h0C, 8'h77); chk("R8 direct", {7'b0, txv_seen}, 8'h01);
        chk("R8 data2", txd_seen, 8'h77);
        rd(6'h04, v); chk("R8 empty stays", v, 8'h0C);
        wr(6'h14, 8'h01); chk("R6 txint irq", {7'b0, irq}, 8'h01);
        rd(6'h14, v); chk("R5 isr", v, 8'h01);
        wr(6'h14, 8'h00); chk("R5 masked", {7'b0, irq}, 8'h00);

        // R9 transmitter reset
        wr(6'h08, 8'h08);
        wr(6'h0C, 8'h99);
        wr(6'h08, 8'h30);
        rd(6'h04, v); chk("R9 status", v, 8'h08);
        wr(6'h08, 8'h04); chk("R9 dropped", {7'b0, txv_seen}, 8'h00);
        // R7 field order: reset then enable in one byte
        wr(6'h08, 8'h08);
        wr(6'h0C, 8'h55);
        wr(6'h08, 8'h34); chk("R7 order no send", {7'b0, txv_seen}, 8'h00);
        rd(6'h04, v); chk("R7 order status", v, 8'h0C);
        wr(6'h08, 8'h0F); chk("R7 reserved", {7'b0, txv_seen}, 8'h00);
        rd(6'h04, v); chk("R7 reserved status", v, 8'h0C);

        // R7 sweep of transmitter and receiver fields from both start states
        for (int base = 0; base < 2; base++) begin
            for (int t = 0; t < 4; t++) begin
                for (int r = 0; r < 4; r++) begin
                    logic et, er;
                    wr(6'h08, base == 1 ? 8'h05 : 8'h0A);
                    wr(6'h08, {4'b0000, 2'(t), 2'(r)});
                    et = (t == 1) ? 1'b1 : (t == 2) ? 1'b0 : base[0];
                    er = (r == 1) ? 1'b1 : (r == 2) ? 1'b0 : base[0];
                    rd(6'h04, v); chk("R7 sweep status", v, {5'b00001, et, 2'b00});
                    chk("R7 sweep rx", {7'b0, rx_ready}, {7'b0, er});
                end
            end
        end

        // R10 and R6 receive queue with full-driven interrupt
        wr(6'h08, 8'h28);
        wr(6'h08, 8'h01);
        wr(6'h14, 8'h02);
        wr(6'h08, 8'h10);
        wr(6'h00, 8'h40);
        for (int i = 0; i < 4; i++) begin
            push(8'h10 + 8'(i));
            rd(6'h04, v); chk("R10 R4 fill status", v, (i == 3) ? 8'h0B : 8'h09);
            chk("R6 full irq", {7'b0, irq}, (i == 3) ? 8'h01 : 8'h00);
            chk("R10 ready", {7'b0, rx_ready}, (i == 3) ? 8'h00 : 8'h01);
        end
        push(8'hEE);
        for (int i = 0; i < 4; i++) begin
            rd(6'h0C, v); chk("R10 order", v, 8'h10 + 8'(i));
        end
        rd(6'h0C, v); chk("R10 empty read", v, 8'h00);
        rd(6'h04, v); chk("R10 drained", v, 8'h08);

        // R6 ready-driven interrupt
        wr(6'h08, 8'h10);
        wr(6'h00, 8'h00);
        push(8'h21);
        chk("R6 ready irq", {7'b0, irq}, 8'h01);
        rd(6'h14, v); chk("R6 isr", v, 8'h02);

        // R11 break overwrite
        push(8'h22); push(8'h23); push(8'h24);
        brk();
        rd(6'h14, v); chk("R11 flag", v, 8'h06);
        rd(6'h0C, v); chk("R11 q0", v, 8'h21);
        rd(6'h0C, v); chk("R11 q1", v, 8'h22);
        rd(6'h0C, v); chk("R11 q2", v, 8'h23);
        rd(6'h0C, v); chk("R11 overwrite", v, 8'h00);
        wr(6'h08, 8'h50);
        rd(6'h14, v); chk("R11 clear", v, 8'h00);
        wr(6'h08, 8'h02);
        brk();
        rd(6'h04, v); chk("R11 disabled push", v, 8'h09);

        // R12 receiver reset
        wr(6'h08, 8'h01);
        push(8'h31);
        wr(6'h08, 8'h20);
        rd(6'h04, v); chk("R12 status", v, 8'h08);
        chk("R12 ready", {7'b0, rx_ready}, 8'h00);
        rd(6'h0C, v); chk("R12 flushed", v, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule